// File: doc/BRIEF.md
# Lane Divergence Mask Unit

This block tracks control-flow divergence for a group of lanes that run under one shared program counter. Divergence is never shown by giving lanes their own program counters. It is shown only through an execution mask. Each lane keeps a small suspension counter that records how many enclosing conditionals are currently holding it off. A lane runs only while its counter is zero.

A sequencer drives three one-cycle control pulses: one for if, one for else and one for endif. With the if pulse it also drives a per-lane condition vector. The unit updates every lane counter on the clock edge that samples a pulse. From the updated counters it produces the active lane mask. It also raises an all-idle flag when no lane is active, which lets the sequencer skip a block that no lane would execute.

When a counter would pass its maximum, a sticky depth-error flag is raised. The flag stays set until reset.

Top module: `lane_divergence_mask`

## Requirements
- R1: While rst_n is low at a clock edge, every counter clears. After that edge all mask bits are 1, all_idle_o is 0 and depth_err_o is 0.
- R2: On an if pulse, an active lane (counter 0) whose lane_cond_i bit is 1 stays active. An active lane whose bit is 0 gets counter 1 and goes inactive.
- R3: On an if pulse, a lane that is already suspended (counter nonzero) increments its counter whatever its condition bit. One endif therefore undoes exactly one if.
- R4: On an else pulse, a lane with counter 1 returns to 0, and an active lane moves to 1. A lane with counter 2 or more keeps its count.
- R5: On an endif pulse, every lane with a nonzero counter decrements by one. Lanes at 0 stay at 0.
- R6: Bit n of active_mask_o is 1 exactly when lane n's counter is 0. all_idle_o is 1 exactly when no counter is 0. Both change in the cycle after the edge that sampled the pulse, and neither lags the other.
- R7: An if pulse that would increment a counter already at its maximum (2^CNT_W-1) leaves that counter at the maximum. It also sets depth_err_o, which stays 1 until reset.
- R8: When several pulses are high in the same cycle, only one takes effect, with the priority if over else over endif.
- R9: In a cycle with no pulse, no counter changes. lane_cond_i is ignored in any cycle without an if pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_cond_i | input | LANES | Per-lane condition, sampled with if_pulse_i |
| if_pulse_i | input | 1 | Enter a conditional block |
| else_pulse_i | input | 1 | Swap to the else side of the current block |
| endif_pulse_i | input | 1 | Leave the current conditional block |
| active_mask_o | output | LANES | 1 for each lane whose counter is zero |
| all_idle_o | output | 1 | No lane is active |
| depth_err_o | output | 1 | Sticky counter-overflow flag |

## Verification
The bench builds the unit with its default parameters: 32 lanes and 4-bit counters. With a 4-bit counter, a lane that went inactive on its first if reaches the maximum after 14 more ifs. That makes saturation and the sticky error reachable in a few dozen cycles, and a full set of endifs can then drain the counter back to zero. Thirty-two lanes allow mixed condition patterns, so lanes sit at counts 0, 1 and 2 or more at the same time during an else. An all-false condition drives every lane idle.

// File: rtl/dmask_pkg.sv
// Shared types for the divergence mask unit.
// Assumes at most one control operation takes effect per cycle.
package dmask_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_IF    = 2'd1,
        OP_ELSE  = 2'd2,
        OP_ENDIF = 2'd3
    } ctl_op_e;
endpackage

// File: rtl/dmask_op_decode.sv
// Collapses the three control pulses into one operation code.
// Assumes pulses may overlap; priority is if, then else, then endif.
module dmask_op_decode
    import dmask_pkg::*;
(
    input  logic    if_pulse_i,
    input  logic    else_pulse_i,
    input  logic    endif_pulse_i,
    output ctl_op_e op_o
);
    // Priority pick of the operation for this cycle.
    always_comb begin
        if (if_pulse_i)         op_o = OP_IF;
        else if (else_pulse_i)  op_o = OP_ELSE;
        else if (endif_pulse_i) op_o = OP_ENDIF;
        else                    op_o = OP_NONE;
    end
endmodule

// File: rtl/dmask_lane_ctr.sv
// One lane's suspension counter; the lane is active when the count is zero.
// Assumes op_i is already priority-decoded and stable around the clock edge.
module dmask_lane_ctr
    import dmask_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ctl_op_e op_i,
    input  logic    cond_i,
    output logic    active_o,
    output logic    ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Next count from the current operation.
    always_comb begin
        cnt_d = cnt_q;
        ovf_o = 1'b0;
        unique case (op_i)
            OP_IF: begin
                if (cnt_q == '0) begin
                    if (!cond_i) cnt_d = CNT_ONE;
                end else if (cnt_q == CNT_MAX) begin
                    ovf_o = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            OP_ELSE: begin
                if (cnt_q == '0)          cnt_d = CNT_ONE;
                else if (cnt_q == CNT_ONE) cnt_d = '0;
            end
            OP_ENDIF: begin
                if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
            end
            default: cnt_d = cnt_q;
        endcase
    end

    // Counter register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Lane runs only while nothing suspends it.
    assign active_o = (cnt_q == '0);

    p_susp_if_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_IF && !active_o && !ovf_o) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
    p_endif_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ENDIF && !active_o) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
    p_else_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_ELSE && cnt_q > CNT_ONE) |=> $stable(cnt_q));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NONE) |=> $stable(active_o));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/dmask_reduce.sv
// Reduces per-lane flags into group flags: all-idle and any-overflow.
// Assumes inputs come straight from the lane counters.
module dmask_reduce #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] ovf_i,
    output logic             idle_o,
    output logic             ovf_any_o
);
    // Group-level flags from lane vectors.
    always_comb begin
        idle_o    = ~(|mask_i);
        ovf_any_o = |ovf_i;
    end
endmodule

// File: rtl/lane_divergence_mask.sv
// Top of the divergence mask unit: per-lane counters, mask and flags.
// Assumes control pulses last one cycle each; overlapping pulses are
// resolved by priority.
module lane_divergence_mask
    import dmask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_cond_i,
    input  logic             if_pulse_i,
    input  logic             else_pulse_i,
    input  logic             endif_pulse_i,
    output logic [LANES-1:0] active_mask_o,
    output logic             all_idle_o,
    output logic             depth_err_o
);
    ctl_op_e          op;
    logic [LANES-1:0] ovf_vec;
    logic             ovf_any;
    logic             err_q;

    dmask_op_decode u_dec (
        .if_pulse_i    (if_pulse_i),
        .else_pulse_i  (else_pulse_i),
        .endif_pulse_i (endif_pulse_i),
        .op_o          (op)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmask_lane_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .op_i     (op),
            .cond_i   (lane_cond_i[g]),
            .active_o (active_mask_o[g]),
            .ovf_o    (ovf_vec[g])
        );
    end

    dmask_reduce #(.LANES(LANES)) u_red (
        .mask_i    (active_mask_o),
        .ovf_i     (ovf_vec),
        .idle_o    (all_idle_o),
        .ovf_any_o (ovf_any)
    );

    // Sticky depth error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | ovf_any;
    end

    assign depth_err_o = err_q;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (active_mask_o == '1 && !depth_err_o));
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_err_o |=> depth_err_o);
    p_idle_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (all_idle_o |-> $countones(active_mask_o) == 0));
    p_if_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (if_pulse_i && (else_pulse_i || endif_pulse_i) && lane_cond_i == '1 && active_mask_o == '1)
        |=> (active_mask_o == '1));
endmodule

// File: tb/lane_divergence_mask_tb_top.sv
module lane_divergence_mask_tb_top;
    localparam int LANES  = 32;
    localparam int CNT_W  = 4;
    localparam int CMAX   = (1 << CNT_W) - 1;
    localparam int PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LANES-1:0] cond;
    logic             p_if, p_else, p_endif;
    logic [LANES-1:0] mask;
    logic             idle, err;

    int  ref_cnt [LANES];
    bit  ref_err;
    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #(PERIOD/2) clk = ~clk;

    lane_divergence_mask #(.LANES(LANES), .CNT_W(CNT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane_cond_i   (cond),
        .if_pulse_i    (p_if),
        .else_pulse_i  (p_else),
        .endif_pulse_i (p_endif),
        .active_mask_o (mask),
        .all_idle_o    (idle),
        .depth_err_o   (err)
    );

    // Behavioural reference update for one clock edge.
    task automatic model_step(input bit rst, input bit i, input bit e, input bit d,
                              input logic [LANES-1:0] c);
        if (rst) begin
            foreach (ref_cnt[k]) ref_cnt[k] = 0;
            ref_err = 0;
            return;
        end
        foreach (ref_cnt[k]) begin
            if (i) begin
                if (ref_cnt[k] == 0) ref_cnt[k] = c[k] ? 0 : 1;
                else if (ref_cnt[k] == CMAX) ref_err = 1;
                else ref_cnt[k]++;
            end else if (e) begin
                if (ref_cnt[k] == 0) ref_cnt[k] = 1;
                else if (ref_cnt[k] == 1) ref_cnt[k] = 0;
            end else if (d) begin
                if (ref_cnt[k] > 0) ref_cnt[k]--;
            end
        end
    endtask

    task automatic compare(input string tag);
        logic [LANES-1:0] exp_mask;
        bit exp_idle;
        foreach (ref_cnt[k]) exp_mask[k] = (ref_cnt[k] == 0);
        exp_idle = (exp_mask == '0);
        n_checks++;
        if (mask !== exp_mask || idle !== exp_idle || err !== ref_err) begin
            n_fail++;
            $display("FAIL %s: mask=%h idle=%b err=%b expected mask=%h idle=%b err=%b",
                     tag, mask, idle, err, exp_mask, exp_idle, ref_err);
        end
    endtask

    // Drive one cycle, update model at the edge, compare a quarter period later.
    task automatic cyc(input bit rst, input bit i, input bit e, input bit d,
                       input logic [LANES-1:0] c, input string tag);
        rst_n = !rst; p_if = i; p_else = e; p_endif = d; cond = c;
        @(posedge clk);
        model_step(rst, i, e, d, c);
        #(PERIOD/4);
        compare(tag);
        rst_n = 1; p_if = 0; p_else = 0; p_endif = 0;
    endtask

    initial begin
        rst_n = 0; p_if = 0; p_else = 0; p_endif = 0; cond = '0;
        foreach (ref_cnt[k]) ref_cnt[k] = 0;
        ref_err = 0;
        cyc(1, 0, 0, 0, '0, "R1 reset");
        cyc(1, 1, 0, 0, 32'h0F0F_1234, "R1 reset holds");
        cyc(0, 0, 0, 0, 32'hFFFF_0000, "R9 idle cond ignored");
        cyc(0, 1, 0, 0, 32'hA5A5_00FF, "R2 if split");
        cyc(0, 1, 0, 0, 32'h0F0F_0F0F, "R3 nested if");
        cyc(0, 0, 0, 0, 32'h1234_5678, "R9 hold");
        cyc(0, 0, 1, 0, '0, "R4 else mixed depths");
        cyc(0, 0, 0, 1, '0, "R5 endif inner");
        cyc(0, 0, 1, 0, '0, "R4 else outer");
        cyc(0, 0, 0, 1, '0, "R5 endif outer");
        cyc(0, 1, 0, 0, '0, "R6 all false idle");
        cyc(0, 0, 1, 0, '0, "R6 else wakes all");
        cyc(0, 0, 0, 1, '0, "R5 back to active");
        cyc(0, 1, 1, 1, 32'hFFFF_FFFF, "R8 if wins");
        cyc(0, 0, 1, 1, '0, "R8 else over endif");
        cyc(0, 0, 0, 1, '0, "R5 drain");
        cyc(0, 0, 0, 1, '0, "R5 drain at zero");
        for (int n = 0; n < CMAX + 2; n++)
            cyc(0, 1, 0, 0, 32'h0000_FFFF, "R7 deep nesting");
        cyc(0, 0, 0, 0, 32'hFFFF_FFFF, "R7 error sticky");
        cyc(0, 0, 1, 0, '0, "R4 else at max");
        for (int n = 0; n < CMAX; n++)
            cyc(0, 0, 0, 1, '0, "R5 unwind");
        cyc(0, 0, 0, 0, '0, "R7 still sticky");
        cyc(1, 0, 0, 0, '0, "R1 reset clears error");
        for (int n = 0; n < 40; n++)
            cyc(0, (n % 3) == 0, (n % 5) == 1, (n % 4) == 2,
                32'h9E37_79B9 * (n + 1), "R2 mixed sequence");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule